// File: doc/BRIEF.md
# Smart Card Session Power Sequencer

This block switches a card slot on and off in a fixed, safe order. A host pulls an active-low session command to ask for a card session. The host also supplies a reset level that is forwarded to the card. On a session request the block turns on the card supply and then checks that the supply is good. It then puts the data and auxiliary lines into reception mode, opens the card clock gate, and finally lets card reset follow the host reset. Card reset is released only after a long hold-off, counted in card clock cycles.

Any of four conditions during a session starts an automatic shutdown and latches an active-low fault flag to the host. These are over-current, over-temperature, a supply fault and removal of the card. A host release of the command also starts a shutdown. The shutdown always drops reset, then clock, then the I/O lines, then the supply, with a programmable spacing between steps. All delays are counted on `tick`, an enable pulse taken from a 1.5 MHz time base. The default interval values assume that rate. The card clock hold-off counts `card_clk_pulse`, a synchronous pulse that marks each rising edge of the gated card clock.

Top module: `card_power_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, card_vcc_en, io_rx, card_clk_en and card_rst are 0 and fault_n is 1. A session starts only when host_cmd_n is 0 while host_rst is 1. With host_rst at 0, a low host_cmd_n leaves all outputs at 0.
- R2: One clock after a valid session request, card_vcc_en goes to 1. supply_good is sampled when the supply interval of SUPPLY_TICKS ticks ends. If it is 0 then, fault_n goes to 0 and the shutdown sequence begins.
- R3: io_rx goes to 1 after the supply interval plus a further IO_TICKS interval. With tick high on every clock, this is SUPPLY_TICKS+IO_TICKS+2 clocks after card_vcc_en rises.
- R4: card_clk_en goes to 1 after a further CLK_TICKS interval following io_rx, which is CLK_TICKS+1 clocks later with tick high on every clock.
- R5: card_rst stays 0 until RST_HOLD_CYCLES card_clk_pulse events have been counted while the card clock is enabled, even if host_rst is already 1. It rises on the clock after the count is reached.
- R6: Once the hold-off has passed, card_rst follows host_rst with a delay of one clock in both directions.
- R7: A host_cmd_n of 1 during a session causes the following, with each step STEP_TICKS+1 clocks after the previous one when tick is high on every clock: card_rst falls, then card_clk_en, then io_rx, then card_vcc_en. The block then returns to idle.
- R8: During a session, a 1 on flt_overcurrent, flt_overtemp or flt_supply, or a 0 on card_present, drives fault_n to 0 on the next clock and starts the same ordered shutdown.
- R9: fault_n stays 0 until the block is idle and host_cmd_n is 1. While it is 0, a low host_cmd_n does not start a session.
- R10: A session request that arrives during a shutdown is ignored until card_vcc_en has fallen. A request still present then starts a new session on the next clock.
- R11: Fault inputs have no effect while the block is idle: fault_n stays 1 and all card outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable pulse (1.5 MHz rate) |
| card_clk_pulse | input | 1 | One-clock pulse per rising edge of the gated card clock |
| host_cmd_n | input | 1 | Session request, active low |
| host_rst | input | 1 | Host reset level to forward to the card |
| supply_good | input | 1 | Card supply is within range |
| flt_overcurrent | input | 1 | Over-current fault |
| flt_overtemp | input | 1 | Over-temperature fault |
| flt_supply | input | 1 | Supply fault |
| card_present | input | 1 | Card detected in the slot |
| card_vcc_en | output | 1 | Card supply enable |
| io_rx | output | 1 | 1: I/O lines in reception mode, 0: held low |
| card_clk_en | output | 1 | Card clock gate enable |
| card_rst | output | 1 | Card reset line |
| fault_n | output | 1 | Latched fault flag to host, active low |

## Verification
Every output is registered, so a change on an input that the state machine can act on shows at the outputs one clock later. A timed phase of N ticks lasts N+1 clocks when tick is high on every clock. The exact due cycles follow from this. The supply enable is due 1 clock after the request. Reception mode is due SUPPLY_TICKS+IO_TICKS+2 clocks after the supply enable, and the clock gate CLK_TICKS+1 clocks after that. Card reset is due RST_HOLD_CYCLES+1 clocks after the clock gate opens. Each shutdown step is due STEP_TICKS+1 clocks after the previous one.

The bench drives inputs and samples outputs on falling edges, and keeps a count of samples since the last stimulus. Each check is taken both at the exact due sample and at the sample just before it. A result that comes one cycle early or late is therefore seen.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR_UP,
        ST_IO_WAIT,
        ST_CLK_WAIT,
        ST_ACTIVE,
        ST_DN_RST,
        ST_DN_CLK,
        ST_DN_IO,
        ST_DN_VCC
    } seq_state_e;

    // registered state of the sequencer
    typedef struct packed {
        seq_state_e state;
        logic       vcc;
        logic       io;
        logic       clk;
        logic       rst;
        logic       fault;   // 1: fault latched
    } seq_regs_t;

endpackage

// File: rtl/cps_tick_timer.sv
module cps_tick_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (tick && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cps_hold_counter.sv
module cps_hold_counter #(
    parameter int LIMIT = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic edge_pulse,
    output logic reached
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (edge_pulse && (cnt_q < LIM))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reached = (cnt_q == LIM);
endmodule

// File: rtl/cps_fault_merge.sv
module cps_fault_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] src,
    output logic         any
);
    logic [N:0] chain;
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_or
        assign chain[i+1] = chain[i] | src[i];
    end

    assign any = chain[N];
endmodule

// File: rtl/card_power_sequencer.sv
module card_power_sequencer
    import cps_pkg::*;
#(
    parameter int SUPPLY_TICKS    = 765,
    parameter int IO_TICKS        = 3,
    parameter int CLK_TICKS       = 1,
    parameter int STEP_TICKS      = 3,
    parameter int RST_HOLD_CYCLES = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic card_clk_pulse,
    input  logic host_cmd_n,
    input  logic host_rst,
    input  logic supply_good,
    input  logic flt_overcurrent,
    input  logic flt_overtemp,
    input  logic flt_supply,
    input  logic card_present,
    output logic card_vcc_en,
    output logic io_rx,
    output logic card_clk_en,
    output logic card_rst,
    output logic fault_n
);
    localparam int NUM_FLT = 4;
    localparam int T_MAX01 = (SUPPLY_TICKS > IO_TICKS) ? SUPPLY_TICKS : IO_TICKS;
    localparam int T_MAX23 = (CLK_TICKS > STEP_TICKS) ? CLK_TICKS : STEP_TICKS;
    localparam int T_MAX   = (T_MAX01 > T_MAX23) ? T_MAX01 : T_MAX23;
    localparam int TW      = $clog2(T_MAX + 1);

    localparam logic [TW-1:0] LD_SUPPLY = TW'(SUPPLY_TICKS);
    localparam logic [TW-1:0] LD_IO     = TW'(IO_TICKS);
    localparam logic [TW-1:0] LD_CLK    = TW'(CLK_TICKS);
    localparam logic [TW-1:0] LD_STEP   = TW'(STEP_TICKS);

    seq_regs_t     r_d, r_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          hold_reached;
    logic          fault_any;
    logic          go_down;

    cps_fault_merge #(.N(NUM_FLT)) u_flt (
        .src ({flt_overcurrent, flt_overtemp, flt_supply, ~card_present}),
        .any (fault_any)
    );

    cps_tick_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    cps_hold_counter #(.LIMIT(RST_HOLD_CYCLES)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (r_q.clk),
        .edge_pulse (card_clk_pulse),
        .reached    (hold_reached)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        go_down  = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                r_d.vcc = 1'b0;
                r_d.io  = 1'b0;
                r_d.clk = 1'b0;
                r_d.rst = 1'b0;
                if (host_cmd_n)
                    r_d.fault = 1'b0;
                if (!host_cmd_n && host_rst && !r_q.fault) begin
                    r_d.state = ST_PWR_UP;
                    r_d.vcc   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SUPPLY;
                end
            end
            ST_PWR_UP: begin
                if (host_cmd_n || fault_any) begin
                    go_down = 1'b1;
                end else if (tmr_done) begin
                    if (supply_good) begin
                        r_d.state = ST_IO_WAIT;
                        tmr_load  = 1'b1;
                        tmr_val   = LD_IO;
                    end else begin
                        r_d.fault = 1'b1;
                        go_down   = 1'b1;
                    end
                end
            end
            ST_IO_WAIT: begin
                if (host_cmd_n || fault_any) begin
                    go_down = 1'b1;
                end else if (tmr_done) begin
                    r_d.io    = 1'b1;
                    r_d.state = ST_CLK_WAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_CLK;
                end
            end
            ST_CLK_WAIT: begin
                if (host_cmd_n || fault_any) begin
                    go_down = 1'b1;
                end else if (tmr_done) begin
                    r_d.clk   = 1'b1;
                    r_d.state = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (host_cmd_n || fault_any)
                    go_down = 1'b1;
                else
                    r_d.rst = host_rst && hold_reached;
            end
            ST_DN_RST: begin
                if (tmr_done) begin
                    r_d.rst   = 1'b0;
                    r_d.state = ST_DN_CLK;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_STEP;
                end
            end
            ST_DN_CLK: begin
                if (tmr_done) begin
                    r_d.clk   = 1'b0;
                    r_d.state = ST_DN_IO;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_STEP;
                end
            end
            ST_DN_IO: begin
                if (tmr_done) begin
                    r_d.io    = 1'b0;
                    r_d.state = ST_DN_VCC;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_STEP;
                end
            end
            ST_DN_VCC: begin
                if (tmr_done) begin
                    r_d.vcc   = 1'b0;
                    r_d.state = ST_IDLE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        if (go_down) begin
            r_d.state = ST_DN_RST;
            tmr_load  = 1'b1;
            tmr_val   = LD_STEP;
            if (fault_any)
                r_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.vcc   <= 1'b0;
            r_q.io    <= 1'b0;
            r_q.clk   <= 1'b0;
            r_q.rst   <= 1'b0;
            r_q.fault <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign card_vcc_en = r_q.vcc;
    assign io_rx       = r_q.io;
    assign card_clk_en = r_q.clk;
    assign card_rst    = r_q.rst;
    assign fault_n     = ~r_q.fault;
endmodule

// File: rtl/cps_seq_checker.sv
module cps_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic host_cmd_n,
    input logic host_rst,
    input logic supply_good,
    input logic flt_overcurrent,
    input logic flt_overtemp,
    input logic flt_supply,
    input logic card_present,
    input logic card_vcc_en,
    input logic io_rx,
    input logic card_clk_en,
    input logic card_rst,
    input logic fault_n,
    input logic hold_reached
);
    // R5
    rst_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (card_clk_en && io_rx && card_vcc_en));

    // R4
    clock_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk_en |-> (io_rx && card_vcc_en));

    // R3
    io_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rx |-> card_vcc_en);

    // R5
    rst_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst) |-> $past(hold_reached));

    // R1
    supply_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_vcc_en) |-> $past(!host_cmd_n && host_rst));

    // R8
    fault_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> $past(flt_overcurrent || flt_overtemp || flt_supply
                                 || !card_present || !supply_good));

    // R7
    supply_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_vcc_en) |-> $past(!io_rx && !card_clk_en && !card_rst));
endmodule

bind card_power_sequencer cps_seq_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_cmd_n      (host_cmd_n),
    .host_rst        (host_rst),
    .supply_good     (supply_good),
    .flt_overcurrent (flt_overcurrent),
    .flt_overtemp    (flt_overtemp),
    .flt_supply      (flt_supply),
    .card_present    (card_present),
    .card_vcc_en     (card_vcc_en),
    .io_rx           (io_rx),
    .card_clk_en     (card_clk_en),
    .card_rst        (card_rst),
    .fault_n         (fault_n),
    .hold_reached    (hold_reached)
);

// File: tb/tb_card_power_sequencer.sv
module tb_card_power_sequencer;
    localparam int S_T  = 8;
    localparam int IO_T = 3;
    localparam int CK_T = 1;
    localparam int ST_T = 2;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic card_clk_pulse = 1'b1;
    logic host_cmd_n = 1'b1;
    logic host_rst = 1'b1;
    logic supply_good = 1'b1;
    logic flt_overcurrent = 1'b0;
    logic flt_overtemp = 1'b0;
    logic flt_supply = 1'b0;
    logic card_present = 1'b1;
    logic card_vcc_en, io_rx, card_clk_en, card_rst, fault_n;

    int checks = 0;
    int failures = 0;
    int cur = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    card_power_sequencer #(
        .SUPPLY_TICKS(S_T), .IO_TICKS(IO_T), .CLK_TICKS(CK_T),
        .STEP_TICKS(ST_T), .RST_HOLD_CYCLES(HOLD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .card_clk_pulse(card_clk_pulse),
        .host_cmd_n(host_cmd_n), .host_rst(host_rst), .supply_good(supply_good),
        .flt_overcurrent(flt_overcurrent), .flt_overtemp(flt_overtemp),
        .flt_supply(flt_supply), .card_present(card_present),
        .card_vcc_en(card_vcc_en), .io_rx(io_rx), .card_clk_en(card_clk_en),
        .card_rst(card_rst), .fault_n(fault_n)
    );

    // expected bits: {vcc, io, clk, rst, fault_n}
    localparam int NA = 7;
    localparam int ACT_K [NA] = '{0, 12, 13, 14, 15, 35, 36};
    localparam logic [4:0] ACT_E [NA] =
        '{5'b10001, 5'b10001, 5'b11001, 5'b11001, 5'b11101, 5'b11101, 5'b11111};
    localparam int NDN = 8;
    localparam int DN_K [NDN] = '{2, 3, 5, 6, 8, 9, 11, 12};
    localparam logic [4:0] DN_E [NDN] =
        '{5'b11111, 5'b11101, 5'b11101, 5'b11001, 5'b11001, 5'b10001, 5'b10001, 5'b00001};

    // sample index k is the falling edge k+1 clocks after the stimulus
    task automatic mark();
        cur = -1;
    endtask

    task automatic run_to(input int k);
        while (cur < k) begin
            @(negedge clk);
            cur++;
        end
    endtask

    task automatic check(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {card_vcc_en, io_rx, card_clk_en, card_rst, fault_n};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s sample=%0d actual=%b expected=%b", tag, cur, act, exp);
        end
    endtask

    task automatic activate_full();
        host_rst = 1'b1;
        host_cmd_n = 1'b0;
        mark();
        for (int i = 0; i < NA; i++) begin
            run_to(ACT_K[i]);
            // R2 supply, R3 io, R4 clock, R5 reset hold-off
            check(i < 2 ? "R2" : (i < 4 ? "R3" : (i < 6 ? "R4_R5" : "R5")), ACT_E[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 5'b00001);

        // R1: no start without host reset high
        host_rst = 1'b0;
        host_cmd_n = 1'b0;
        mark();
        run_to(3);
        check("R1", 5'b00001);
        host_cmd_n = 1'b1;
        run_to(5);

        // table-driven activation then deactivation
        activate_full();

        // R6: reset follows host
        host_rst = 1'b0; mark(); run_to(0);
        check("R6", 5'b11101);
        host_rst = 1'b1; mark(); run_to(0);
        check("R6", 5'b11111);

        host_cmd_n = 1'b1;
        mark();
        for (int i = 0; i < NDN; i++) begin
            run_to(DN_K[i]);
            check("R7", DN_E[i]);
        end

        // R11: faults ignored while idle
        flt_overcurrent = 1'b1; card_present = 1'b0;
        mark(); run_to(2);
        check("R11", 5'b00001);
        flt_overcurrent = 1'b0; card_present = 1'b1;
        run_to(3);

        // R8/R9: over-temperature during a session
        activate_full();
        run_to(40);
        flt_overtemp = 1'b1;
        mark(); run_to(0);
        flt_overtemp = 1'b0;
        check("R8", 5'b11110);
        run_to(2);  check("R8", 5'b11110);
        run_to(3);  check("R8", 5'b11100);
        run_to(12); check("R8", 5'b00000);
        run_to(20); check("R9", 5'b00000);
        host_cmd_n = 1'b1;
        mark(); run_to(0);
        check("R9", 5'b00001);
        run_to(2);

        // R8: card removal before reset released
        host_cmd_n = 1'b0;
        mark(); run_to(20);
        card_present = 1'b0;
        mark(); run_to(0);
        check("R8", 5'b11100);
        run_to(12); check("R8", 5'b00000);
        card_present = 1'b1;
        host_cmd_n = 1'b1;
        mark(); run_to(0);
        check("R9", 5'b00001);

        // R2: supply never confirmed
        supply_good = 1'b0;
        host_cmd_n = 1'b0;
        mark();
        run_to(S_T);      check("R2", 5'b10001);
        run_to(S_T + 1);  check("R2", 5'b10000);
        run_to(S_T + 12); check("R2", 5'b10000);
        run_to(S_T + 13); check("R2", 5'b00000);
        supply_good = 1'b1;
        host_cmd_n = 1'b1;
        mark(); run_to(1);
        check("R9", 5'b00001);

        // R10: request during shutdown waits for completion
        activate_full();
        host_cmd_n = 1'b1;
        mark(); run_to(4);
        host_cmd_n = 1'b0;
        run_to(12); check("R10", 5'b00001);
        run_to(13); check("R10", 5'b10001);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule